// File: doc/BRIEF.md
# Transmit-Side Arbitration and Bit Monitor

This block sits beside the transmitter of a node on a wired-AND serial bus. On a wired-AND bus a dominant level (logic 0) overrides a recessive level (logic 1). On every sample strobe the block compares the bit the node is driving with the bit read back from the bus. It uses field flags from the frame sequencer to judge what a mismatch means.

Inside the arbitration field, a node that sends recessive and reads dominant has lost to a lower, higher-priority identifier. The block then withdraws transmit permission and latches a lost flag, and raises no error. The arbitration flag is held by the sequencer for the whole identifier field, so the same logic serves 11-bit and 29-bit identifiers.

Reading dominant after sending recessive is also excused in two other places: in the acknowledge slot, and while a passive error flag is being sent. Any other mismatch produces a one-cycle bit-error pulse for the error counting logic. Transmit permission is granted only at a frame start seen while the bus is idle.

Top module: `arb_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `lost_arb`, `tx_enable` and `bit_err` are all 0.
- R2: A `frame_start` pulse while `bus_idle` is 1 clears `lost_arb` and sets `tx_enable` to the value of `tx_request`, visible after that clock edge.
- R3: A `frame_start` pulse while `bus_idle` is 0 is ignored: `tx_enable` and `lost_arb` keep their values.
- R4: On a strobe with `tx_enable`=1 and `arb_field`=1, a sent 1 and a read 0 set `lost_arb` to 1 and clear `tx_enable` after that edge. No `bit_err` pulse is raised.
- R5: `lost_arb` stays at 1 until the next accepted frame start (R2).
- R6: Any other mismatch between `tx_bit` and `rx_bit` on a strobe with `tx_enable`=1 gives `bit_err`=1 for exactly the one cycle after that edge.
- R7: In the acknowledge slot (`ack_slot`=1), a sent 1 with a read 0 is not a bit error. A sent 0 with a read 1 is a bit error.
- R8: While `passive_flag`=1, a sent 1 with a read 0 is not a bit error.
- R9: Without `sample_en`, bit values have no effect on any output.
- R10: While `tx_enable`=0 the node acts as a receiver, and mismatches raise neither `bit_err` nor a change of `lost_arb`.
- R11: Inside the arbitration field, a sent 0 with a read 1 is a bit error and does not set `lost_arb`.
- R12: Arbitration over identifiers of 11 and of 29 bits, sent MSB first, leaves `lost_arb`=0 exactly when the node's identifier is the lower of the two, or when the two are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Start-of-frame pulse from the sequencer |
| bus_idle | input | 1 | Bus has been detected idle |
| tx_request | input | 1 | Node has a frame to send |
| sample_en | input | 1 | Bit sample strobe |
| tx_bit | input | 1 | Bit the node drives (0 dominant) |
| rx_bit | input | 1 | Bit read back from the bus |
| arb_field | input | 1 | Current bit belongs to the arbitration field |
| ack_slot | input | 1 | Current bit is the acknowledge slot |
| passive_flag | input | 1 | Node is sending a passive error flag |
| lost_arb | output | 1 | Arbitration lost in this frame (sticky) |
| bit_err | output | 1 | One-cycle bit-error pulse |
| tx_enable | output | 1 | Node may drive the bus |

## Verification
Full arbitration contests are run with 11-bit and 29-bit identifiers against rivals that are lower, higher and equal. This separates a loss at the first bit, a loss at the last bit and a win. Single mismatches of both polarities are placed in the arbitration field, the acknowledge slot, the passive-flag window and plain fields. This shows that each exemption covers only the recessive-sent and dominant-read case. Further runs repeat mismatches without a strobe, while receiving, and with a frame start on a busy bus, to show that those inputs are ignored.

// File: rtl/arb_mon_pkg.sv
// Package: shared types for the arbitration monitor.
// Assumes: dominant level is logic 0 on the bus.
package arb_mon_pkg;
    localparam int BIT_W = 1;

    typedef enum logic [1:0] {
        CMP_MATCH  = 2'd0,
        CMP_LOSS   = 2'd1,
        CMP_EXEMPT = 2'd2,
        CMP_ERROR  = 2'd3
    } cmp_res_e;
endpackage

// File: rtl/arb_bit_cmp.sv
// Module: classifies one sent/read bit pair by field context.
// Assumes: field flags are valid whenever the strobe is high.
module arb_bit_cmp
    import arb_mon_pkg::*;
(
    input  logic [BIT_W-1:0] tx_bit,
    input  logic [BIT_W-1:0] rx_bit,
    input  logic             arb_field,
    input  logic             ack_slot,
    input  logic             passive_flag,
    output cmp_res_e         result
);
    logic mismatch;
    logic overridden;

    assign mismatch   = |(tx_bit ^ rx_bit);
    assign overridden = |(tx_bit & ~rx_bit);

    // Decide whether a mismatch is a lost contest, an excused case or an error.
    always_comb begin
        if (!mismatch)
            result = CMP_MATCH;
        else if (overridden && arb_field)
            result = CMP_LOSS;
        else if (overridden && (ack_slot || passive_flag))
            result = CMP_EXEMPT;
        else
            result = CMP_ERROR;
    end
endmodule

// File: rtl/arb_tx_state.sv
// Module: holds transmit permission and the sticky lost flag.
// Assumes: an accepted frame start outranks a loss in the same cycle.
module arb_tx_state (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic bus_idle,
    input  logic tx_request,
    input  logic loss_evt,
    output logic tx_enable,
    output logic lost_arb
);
    logic start_ok;
    assign start_ok = frame_start & bus_idle;

    // Grant on an idle-bus frame start; withdraw on a lost contest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_enable <= 1'b0;
            lost_arb  <= 1'b0;
        end else if (start_ok) begin
            tx_enable <= tx_request;
            lost_arb  <= 1'b0;
        end else if (loss_evt) begin
            tx_enable <= 1'b0;
            lost_arb  <= 1'b1;
        end
    end
endmodule

// File: rtl/arb_err_pulse.sv
// Module: registers the bit-error event into a one-cycle pulse.
// Assumes: the event is already qualified by strobe and permission.
module arb_err_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic err_evt,
    output logic bit_err
);
    // Register the event so the pulse lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) bit_err <= 1'b0;
        else        bit_err <= err_evt;
    end
endmodule

// File: rtl/arb_monitor.sv
// Module: top of the transmit-side arbitration and bit monitor.
// Assumes: inputs are synchronous to clk; sample_en marks the sample point.
module arb_monitor
    import arb_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic bus_idle,
    input  logic tx_request,
    input  logic sample_en,
    input  logic tx_bit,
    input  logic rx_bit,
    input  logic arb_field,
    input  logic ack_slot,
    input  logic passive_flag,
    output logic lost_arb,
    output logic bit_err,
    output logic tx_enable
);
    cmp_res_e cmp_res;
    logic     hit;
    logic     loss_evt;
    logic     err_evt;

    arb_bit_cmp u_cmp (
        .tx_bit      (tx_bit),
        .rx_bit      (rx_bit),
        .arb_field   (arb_field),
        .ack_slot    (ack_slot),
        .passive_flag(passive_flag),
        .result      (cmp_res)
    );

    // Only strobed bits of an active transmitter are judged.
    assign hit      = sample_en & tx_enable;
    assign loss_evt = hit & (cmp_res == CMP_LOSS);
    assign err_evt  = hit & (cmp_res == CMP_ERROR);

    arb_tx_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .bus_idle   (bus_idle),
        .tx_request (tx_request),
        .loss_evt   (loss_evt),
        .tx_enable  (tx_enable),
        .lost_arb   (lost_arb)
    );

    arb_err_pulse u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .err_evt(err_evt),
        .bit_err(bit_err)
    );
endmodule

// File: rtl/arb_monitor_chk.sv
// Module: property checker bound to arb_monitor.
// Assumes: observes top-level ports only.
module arb_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic frame_start,
    input logic bus_idle,
    input logic sample_en,
    input logic tx_bit,
    input logic rx_bit,
    input logic arb_field,
    input logic lost_arb,
    input logic bit_err,
    input logic tx_enable
);
    a_r4_loss_drops_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && tx_enable && arb_field && tx_bit && !rx_bit && !(frame_start && bus_idle))
        |=> (lost_arb && !tx_enable && !bit_err));

    a_r5_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_arb && !(frame_start && bus_idle)) |=> lost_arb);

    a_r3_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !bus_idle && !sample_en) |=> ($stable(tx_enable) && $stable(lost_arb)));

    a_r9_err_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |-> $past(sample_en));

    a_r10_err_needs_tx: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |-> $past(tx_enable));

    a_r11_arb_dom_sent_err: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && tx_enable && arb_field && !tx_bit && rx_bit) |=> bit_err);
endmodule

bind arb_monitor arb_monitor_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .bus_idle   (bus_idle),
    .sample_en  (sample_en),
    .tx_bit     (tx_bit),
    .rx_bit     (rx_bit),
    .arb_field  (arb_field),
    .lost_arb   (lost_arb),
    .bit_err    (bit_err),
    .tx_enable  (tx_enable)
);

// File: tb/arb_monitor_tb_top.sv
// Bench: scoreboard; the driver queues expected outputs, the monitor compares.
module arb_monitor_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 0, bus_idle = 0, tx_request = 0, sample_en = 0;
    logic tx_bit = 1, rx_bit = 1, arb_field = 0, ack_slot = 0, passive_flag = 0;
    logic lost_arb, bit_err, tx_enable;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        logic  lost;
        logic  txen;
        logic  err;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    logic m_lost = 0, m_txen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    arb_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .bus_idle(bus_idle),
        .tx_request(tx_request), .sample_en(sample_en), .tx_bit(tx_bit), .rx_bit(rx_bit),
        .arb_field(arb_field), .ack_slot(ack_slot), .passive_flag(passive_flag),
        .lost_arb(lost_arb), .bit_err(bit_err), .tx_enable(tx_enable)
    );

    // Drive one cycle of stimulus and queue what the requirements predict.
    task automatic drv(input logic fs, input logic idle, input logic req, input logic smp,
                       input logic tb, input logic rb, input logic arb, input logic ack,
                       input logic pf, input string tag);
        exp_t e;
        logic judged, loss, err;
        @(negedge clk);
        frame_start = fs; bus_idle = idle; tx_request = req; sample_en = smp;
        tx_bit = tb; rx_bit = rb; arb_field = arb; ack_slot = ack; passive_flag = pf;
        judged = smp && m_txen && (tb != rb);
        loss   = judged && arb && tb && !rb;
        err    = judged && !loss && !(tb && !rb && (ack || pf));
        if (fs && idle) begin
            m_txen = req;
            m_lost = 0;
        end else if (loss) begin
            m_txen = 0;
            m_lost = 1;
        end
        e.lost = m_lost; e.txen = m_txen; e.err = err; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Run one identifier contest, MSB first, against a rival.
    task automatic contest(input logic [28:0] ours, input logic [28:0] rival,
                           input int len, input string tag);
        drv(1, 1, 1, 0, 1, 1, 0, 0, 0, tag);
        for (int i = len - 1; i >= 0; i--) begin
            logic t;
            t = m_txen ? ours[i] : 1'b1;
            drv(0, 0, 0, 1, t, t & rival[i], 1, 0, 0, tag);
        end
    endtask

    // Scoreboard monitor: compares after each edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_run++;
            if (lost_arb !== e.lost || tx_enable !== e.txen || bit_err !== e.err) begin
                n_fail++;
                $display("FAIL %s: got lost=%b txen=%b err=%b, expected lost=%b txen=%b err=%b",
                         e.tag, lost_arb, tx_enable, bit_err, e.lost, e.txen, e.err);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_run++;
        if (lost_arb !== 0 || tx_enable !== 0 || bit_err !== 0) begin
            n_fail++;
            $display("FAIL R1: got lost=%b txen=%b err=%b, expected 0 0 0", lost_arb, tx_enable, bit_err);
        end
        @(negedge clk); rst_n = 1;
        drv(0, 0, 0, 0, 1, 1, 0, 0, 0, "R1");
        // R3: busy bus start ignored, R2: idle start grants
        drv(1, 0, 1, 0, 1, 1, 0, 0, 0, "R3");
        drv(1, 1, 1, 0, 1, 1, 0, 0, 0, "R2");
        // R9: mismatch without strobe
        drv(0, 0, 0, 0, 0, 1, 0, 0, 0, "R9");
        drv(0, 0, 0, 0, 1, 0, 1, 0, 0, "R9");
        // R6: plain field mismatches of both polarities
        drv(0, 0, 0, 1, 0, 1, 0, 0, 0, "R6");
        drv(0, 0, 0, 1, 1, 0, 0, 0, 0, "R6");
        drv(0, 0, 0, 1, 1, 1, 0, 0, 0, "R6");
        // R7: acknowledge slot
        drv(0, 0, 0, 1, 1, 0, 0, 1, 0, "R7");
        drv(0, 0, 0, 1, 0, 1, 0, 1, 0, "R7");
        // R8: passive flag
        drv(0, 0, 0, 1, 1, 0, 0, 0, 1, "R8");
        drv(0, 0, 0, 1, 0, 1, 0, 0, 1, "R8");
        // R11: dominant sent, recessive read in arbitration
        drv(0, 0, 0, 1, 0, 1, 1, 0, 0, "R11");
        // R4: lost contest bit
        drv(0, 0, 0, 1, 1, 0, 1, 0, 0, "R4");
        // R10 and R5: receiver ignores mismatches, lost held
        drv(0, 0, 0, 1, 0, 1, 0, 0, 0, "R10");
        drv(0, 0, 0, 1, 1, 0, 1, 0, 0, "R10");
        drv(1, 0, 1, 0, 1, 1, 0, 0, 0, "R5");
        drv(0, 0, 0, 0, 1, 1, 0, 0, 0, "R5");
        drv(1, 1, 0, 0, 1, 1, 0, 0, 0, "R2");
        drv(0, 0, 0, 1, 0, 1, 0, 0, 0, "R10");
        // R12: identifier contests, 11 and 29 bits
        contest(29'h123, 29'h124, 11, "R12");
        contest(29'h124, 29'h123, 11, "R12");
        contest(29'h400, 29'h3FF, 11, "R12");
        contest(29'h001, 29'h000, 11, "R12");
        contest(29'h155, 29'h155, 11, "R12");
        contest(29'h0ABCDEF, 29'h0ABCDF0, 29, "R12");
        contest(29'h1FFFFFFF, 29'h1FFFFFFE, 29, "R12");
        contest(29'h10000000, 29'h0FFFFFFF, 29, "R12");
        drv(0, 0, 0, 0, 1, 1, 0, 0, 0, "R5");
        @(posedge clk); #3;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule